// File: doc/BRIEF.md
# Tracking Position Counter with Carry Flags

This block holds the digital angle of a tracking resolver loop. An upstream rate generator sends single-cycle step requests, each with a sign. Every accepted request moves the angle by one LSB, raises a BUSY pulse, keeps a latched DIRECTION flag up to date and, whenever the count wraps through its major carry, raises a RIPPLE flag. External logic can use these flags to count whole revolutions. A preset port writes the counter, either with a plain copy or in a complement mode where every set data bit clears the matching counter bit.

The angle width is chosen at run time by a two-bit code as 10, 12, 14 or 16 bits. Bits above the chosen width take no part in counting or wrap detection and read as zero. The sequencing is a three-state machine. `ST_IDLE` accepts a step (the IDLE-to-LEAD transition, taken on a request with no load in the same cycle). `ST_LEAD` is one cycle in which the new count, DIRECTION and RIPPLE are already visible while BUSY is still low. It always moves on to `ST_PULSE`. `ST_PULSE` holds BUSY high for `BUSY_CYC` cycles and then returns to `ST_IDLE` (the PULSE-to-IDLE transition). The resolution code is sampled only in `ST_IDLE`.

Top module: `angle_track_counter`

## Requirements
- R1: Resolution code c on `res_sel` (0..3) selects 10+2c bits. The count wraps modulo 2^(10+2c), and `pos` bits above that width read 0.
- R2: An accepted step changes `pos` by exactly one LSB: down when `step_down`=1, up when `step_down`=0. The new value appears on the clock edge that accepts the step. No other event changes `pos` except a load.
- R3: A request is accepted only in `ST_IDLE` with `load_en` low. `busy` is low in the cycle after acceptance, then high for exactly `BUSY_CYC` cycles (default 2), then low again. Requests made while not idle are ignored.
- R4: A step from all ones upward or from all zeros downward (within the selected width) sets `ripple` on its accepting edge, one cycle before `busy` rises.
- R5: With no reversal hold pending, the next non-wrapping accepted step clears `ripple` on its accepting edge.
- R6: If a non-wrapping step reverses DIRECTION while `ripple` is high, `ripple` stays high. It clears on the second consecutive BUSY rising edge over which DIRECTION has not changed. A further reversal restarts the count.
- R7: `direction` is 1 for up and 0 for down. It updates only on the accepting edge of a step and leads that step's BUSY pulse by one cycle.
- R8: `load_en` with `load_cpl`=0 writes `load_data` (masked to the width) into the counter on the next edge.
- R9: `load_en` with `load_cpl`=1 clears every counter bit whose data bit is 1 and keeps the rest. For example, 10101 with data 11000 becomes 00101.
- R10: A load wins over a step in the same cycle. That step is dropped (no BUSY), and loads never alter `direction` or `ripple`.
- R11: A change of `res_sel` takes effect only at an edge in `ST_IDLE`. A step accepted on that same edge still uses the previous width.
- R12: After reset, `pos`=0, `busy`=0, `direction`=1 and `ripple`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_req | input | 1 | Step request from the rate generator |
| step_down | input | 1 | Step sign: 1 = count down |
| res_sel | input | 2 | Resolution code, width = 10 + 2*code |
| load_en | input | 1 | Preset strobe |
| load_cpl | input | 1 | Preset mode: 1 = clear-on-set-bits |
| load_data | input | POS_W | Preset word |
| pos | output | POS_W | Angle count, upper unused bits zero |
| busy | output | 1 | Step-in-progress pulse |
| direction | output | 1 | Latched rotation sense, 1 = up |
| ripple | output | 1 | Major-carry flag |

## Verification
The hardest condition to reach is a direction reversal while RIPPLE is high that does not itself wrap. Right after a wrap the count sits on a boundary, so any reversal wraps again. The stimulus therefore wraps, then uses a preset to move the count into the middle of the range, relying on the fact that presets leave the flags alone. It then reverses, continues, and reverses once more to restart the stability count. Full sweeps at 10 and 12 bits cover every count value and both wrap directions. A change of resolution code held across a BUSY pulse, with a request waiting, shows that the first idle step still wraps at the old width.

// File: rtl/atc_pkg.sv
package atc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_PULSE = 2'd2
    } atc_state_t;

    localparam int RES_BASE = 10;
    localparam int RES_INCR = 2;

    function automatic logic [31:0] res_mask(input logic [1:0] code);
        int unsigned nbits;
        nbits = RES_BASE + RES_INCR * int'(code);
        return (32'h1 << nbits) - 32'h1;
    endfunction

endpackage

// File: rtl/atc_step_fsm.sv
module atc_step_fsm
    import atc_pkg::*;
#(
    parameter int BUSY_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_req,
    input  logic load_en,
    output logic acc,
    output logic busy_rise,
    output logic busy,
    output logic idle
);
    localparam int PCW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

    atc_state_t st_q, st_d;
    logic [PCW-1:0] pc_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            pc_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_PULSE) pc_q <= pc_q + 1'b1;
            else                  pc_q <= '0;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (step_req && !load_en) st_d = ST_LEAD;
            ST_LEAD:  st_d = ST_PULSE;
            ST_PULSE: if (pc_q == PCW'(BUSY_CYC - 1)) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle      = (st_q == ST_IDLE);
        acc       = idle && step_req && !load_en;
        busy_rise = (st_q == ST_LEAD);
        busy      = (st_q == ST_PULSE);
    end

endmodule

// File: rtl/atc_counter.sv
module atc_counter
    import atc_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             step_up,
    input  logic [1:0]       res_code,
    input  logic             load_en,
    input  logic             load_cpl,
    input  logic [POS_W-1:0] load_data,
    output logic [POS_W-1:0] pos,
    output logic             wrap
);
    logic [POS_W-1:0] cnt_q, msk, cur;

    assign msk  = POS_W'(res_mask(res_code));
    assign cur  = cnt_q & msk;
    assign wrap = step_up ? (cur == msk) : (cur == '0);
    assign pos  = cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_en) begin
            if (load_cpl) cnt_q <= cur & ~load_data;
            else          cnt_q <= load_data & msk;
        end else if (acc) begin
            if (step_up) cnt_q <= (cur + 1'b1) & msk;
            else         cnt_q <= (cur - 1'b1) & msk;
        end
    end

endmodule

// File: rtl/atc_carry_flags.sv
module atc_carry_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic step_up,
    input  logic wrap,
    input  logic busy_rise,
    output logic dir,
    output logic ripple
);
    localparam int STABLE_EDGES = 2;
    localparam int SW = $clog2(STABLE_EDGES + 1);

    logic          dir_q, rip_q, hold_q, dir_chg;
    logic [SW-1:0] stab_q;

    assign dir_chg = (step_up != dir_q);
    assign dir     = dir_q;
    assign ripple  = rip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= 1'b1;
            rip_q  <= 1'b0;
            hold_q <= 1'b0;
            stab_q <= '0;
        end else if (acc) begin
            dir_q <= step_up;
            if (wrap) begin
                rip_q  <= 1'b1;
                hold_q <= 1'b0;
                stab_q <= '0;
            end else if (rip_q && (hold_q || dir_chg)) begin
                hold_q <= 1'b1;
                if (dir_chg) stab_q <= '0;
            end else begin
                rip_q <= 1'b0;
            end
        end else if (busy_rise && hold_q) begin
            if (stab_q == SW'(STABLE_EDGES - 1)) begin
                rip_q  <= 1'b0;
                hold_q <= 1'b0;
                stab_q <= '0;
            end else begin
                stab_q <= stab_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/angle_track_counter.sv
module angle_track_counter
    import atc_pkg::*;
#(
    parameter int POS_W    = 16,
    parameter int BUSY_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_req,
    input  logic             step_down,
    input  logic [1:0]       res_sel,
    input  logic             load_en,
    input  logic             load_cpl,
    input  logic [POS_W-1:0] load_data,
    output logic [POS_W-1:0] pos,
    output logic             busy,
    output logic             direction,
    output logic             ripple
);
    logic       step_acc, busy_rise, idle, wrap;
    logic [1:0] res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    res_q <= 2'd0;
        else if (idle) res_q <= res_sel;
    end

    atc_step_fsm #(.BUSY_CYC(BUSY_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_req  (step_req),
        .load_en   (load_en),
        .acc       (step_acc),
        .busy_rise (busy_rise),
        .busy      (busy),
        .idle      (idle)
    );

    atc_counter #(.POS_W(POS_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (step_acc),
        .step_up   (!step_down),
        .res_code  (res_q),
        .load_en   (load_en),
        .load_cpl  (load_cpl),
        .load_data (load_data),
        .pos       (pos),
        .wrap      (wrap)
    );

    atc_carry_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (step_acc),
        .step_up   (!step_down),
        .wrap      (wrap),
        .busy_rise (busy_rise),
        .dir       (direction),
        .ripple    (ripple)
    );

endmodule

// File: rtl/atc_checker.sv
module atc_checker
    import atc_pkg::*;
#(
    parameter int POS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc,
    input logic             load_en,
    input logic             busy,
    input logic             direction,
    input logic             ripple,
    input logic [POS_W-1:0] pos,
    input logic [1:0]       res_q
);
    logic [POS_W-1:0] msk;
    assign msk = POS_W'(res_mask(res_q));

    p_pos_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pos & ~msk) == '0);

    p_step_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc) && $stable(res_q)) |->
            ((((pos - $past(pos)) & $past(msk)) == POS_W'(1)) ||
             ((($past(pos) - pos) & $past(msk)) == POS_W'(1))));

    p_hold_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(acc) && !$past(load_en) && $stable(res_q)) |-> $stable(pos));

    p_busy_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !busy);

    p_busy_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##2 busy);

    p_rip_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ripple) |-> ($past(acc) && !busy));

    p_dir_on_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (direction != $past(direction)) |-> $past(acc));

    p_load_keeps_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> $stable(direction));

endmodule

bind angle_track_counter atc_checker #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (step_acc),
    .load_en   (load_en),
    .busy      (busy),
    .direction (direction),
    .ripple    (ripple),
    .pos       (pos),
    .res_q     (res_q)
);

// File: tb/tb_angle_track_counter.sv
module tb_angle_track_counter;
    localparam int POS_W    = 16;
    localparam int BUSY_CYC = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             step_req = 1'b0;
    logic             step_down = 1'b0;
    logic [1:0]       res_sel = 2'd0;
    logic             load_en = 1'b0;
    logic             load_cpl = 1'b0;
    logic [POS_W-1:0] load_data = '0;
    logic [POS_W-1:0] pos;
    logic             busy, direction, ripple;

    angle_track_counter #(.POS_W(POS_W), .BUSY_CYC(BUSY_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_down(step_down),
        .res_sel(res_sel), .load_en(load_en), .load_cpl(load_cpl),
        .load_data(load_data), .pos(pos), .busy(busy),
        .direction(direction), .ripple(ripple)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model
    int m_bits = 10;
    int exp_pos = 0;
    bit exp_dir = 1;
    bit exp_rip = 0;
    bit m_hold = 0;
    int m_stab = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int cur_mask();
        return (1 << m_bits) - 1;
    endfunction

    task automatic set_res(input int code);
        res_sel = 2'(code);
        @(negedge clk);
        m_bits = 10 + 2 * code;
    endtask

    task automatic do_step(input bit up);
        int msk;
        bit wr, chg;
        msk = cur_mask();
        step_req = 1'b1;
        step_down = !up;
        @(posedge clk);
        @(negedge clk);
        step_req = 1'b0;
        wr  = up ? (exp_pos == msk) : (exp_pos == 0);
        chg = (up != exp_dir);
        exp_pos = up ? ((exp_pos + 1) & msk) : ((exp_pos - 1) & msk);
        exp_dir = up;
        if (wr) begin
            exp_rip = 1; m_hold = 0; m_stab = 0;
        end else if (exp_rip && (m_hold || chg)) begin
            m_hold = 1;
            if (chg) m_stab = 0;
        end else begin
            exp_rip = 0;
        end
        chk("R2 step count", int'(pos), exp_pos);
        chk("R7 direction", int'(direction), int'(exp_dir));
        chk(exp_rip ? "R4 ripple set" : "R5 ripple clear", int'(ripple), int'(exp_rip));
        chk("R3 busy low lead", int'(busy), 0);
        @(negedge clk);
        if (m_hold) begin
            if (m_stab == 1) begin
                exp_rip = 0; m_hold = 0; m_stab = 0;
            end else begin
                m_stab++;
            end
        end
        chk("R6 ripple at busy edge", int'(ripple), int'(exp_rip));
        chk("R3 busy high", int'(busy), 1);
        for (int i = 1; i < BUSY_CYC; i++) begin
            @(negedge clk);
            chk("R3 busy high", int'(busy), 1);
        end
        @(negedge clk);
        chk("R3 busy end", int'(busy), 0);
    endtask

    task automatic do_load(input int d, input bit cpl, input bit with_step);
        int msk;
        msk = cur_mask();
        load_en = 1'b1;
        load_cpl = cpl;
        load_data = POS_W'(d);
        step_req = with_step;
        step_down = exp_dir;
        @(negedge clk);
        load_en = 1'b0;
        load_cpl = 1'b0;
        step_req = 1'b0;
        exp_pos = cpl ? (exp_pos & ~d & msk) : (d & msk);
        chk(cpl ? "R9 complement load" : "R8 direct load", int'(pos), exp_pos);
        if (with_step) begin
            chk("R10 dir kept", int'(direction), int'(exp_dir));
            chk("R10 ripple kept", int'(ripple), int'(exp_rip));
            chk("R10 no busy", int'(busy), 0);
            @(negedge clk);
            chk("R10 no busy", int'(busy), 0);
            chk("R10 pos kept", int'(pos), exp_pos);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset pos", int'(pos), 0);
        chk("R12 reset busy", int'(busy), 0);
        chk("R12 reset dir", int'(direction), 1);
        chk("R12 reset ripple", int'(ripple), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R4 R5: full upward sweep at 10 bits with wrap
        for (int i = 0; i < 1030; i++) do_step(1'b1);

        // R1: 12 bits, downward sweep through the wrap
        set_res(1);
        for (int i = 0; i < 4100; i++) do_step(1'b0);

        // R1: 14 and 16 bits near boundaries
        set_res(2);
        do_load(16'h3FFE, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) do_step(1'b1);
        set_res(3);
        do_load(16'h0001, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) do_step(1'b0);

        // R1 R8: upper bits masked at 10 bits
        set_res(0);
        do_load(16'hFFFF, 1'b0, 1'b0);
        chk("R1 upper bits zero", int'(pos), 16'h03FF);

        // R9: complement example and upper-bit data
        do_load(16'h0015, 1'b0, 1'b0);
        do_load(16'h0018, 1'b1, 1'b0);
        chk("R9 example", int'(pos), 16'h0005);
        do_load(16'hFC04, 1'b1, 1'b0);

        // R6: reversal while ripple high, then two stable edges
        do_load(16'h03FF, 1'b0, 1'b0);
        do_step(1'b1);
        do_load(16'h0100, 1'b0, 1'b0);
        do_step(1'b0);
        do_step(1'b0);
        chk("R6 ripple cleared", int'(ripple), 0);
        do_step(1'b0);

        // R6: second reversal restarts the count
        do_load(16'h0000, 1'b0, 1'b0);
        do_step(1'b0);
        do_load(16'h0100, 1'b0, 1'b0);
        do_step(1'b1);
        do_step(1'b0);
        chk("R6 ripple held after re-reversal", int'(ripple), 1);
        do_step(1'b0);
        chk("R6 ripple cleared late", int'(ripple), 0);

        // R10: load beats a simultaneous step of opposite sign
        do_load(16'h0123, 1'b0, 1'b1);
        do_load(16'h0020, 1'b1, 1'b1);

        // R11 R3: resolution change and waiting request held over a pulse
        do_load(16'h03FE, 1'b0, 1'b0);
        step_req = 1'b1;
        step_down = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R2 lead count", int'(pos), 16'h03FF);
        res_sel = 2'd3;
        for (int i = 0; i < BUSY_CYC; i++) begin
            @(negedge clk);
            chk("R3 request ignored while busy", int'(pos), 16'h03FF);
        end
        @(negedge clk);
        chk("R3 idle before accept", int'(busy), 0);
        chk("R11 old width still active", int'(pos), 16'h03FF);
        @(negedge clk);
        step_req = 1'b0;
        chk("R11 wrap at old width", int'(pos), 0);
        chk("R11 ripple on old-width wrap", int'(ripple), 1);
        exp_pos = 0; exp_dir = 1; exp_rip = 1; m_hold = 0; m_stab = 0;
        m_bits = 16;
        repeat (BUSY_CYC + 1) @(negedge clk);
        chk("R3 busy done", int'(busy), 0);
        do_step(1'b1);
        do_load(16'hFFFF, 1'b0, 1'b0);
        chk("R11 new width 16", int'(pos), 16'hFFFF);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule